// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Address Counters

This block is a byte-wide static memory with two fully independent access ports, left (A) and right (B). Both ports sit on one clock. Each port has a pair of chip enables of opposite polarity, a write strobe, an output enable, an address load strobe, a count enable and a counter clear. Between accesses, a port's address register holds its value. On each edge the register either takes the external address, steps up by one, or is cleared to zero. A processor or DMA engine can therefore stream through a buffer without presenting a new address every cycle.

Each port is built with one of two read modes. In flow-through mode the inputs are registered and the read data is combinational from the array. In pipelined mode one more output register is added, so read data and its drive flag appear one cycle later. The bus drivers are modelled as a data bus plus a drive flag. When the flag is low, the data bus reads zero. A write on one port that hits the address the other port is reading is visible to the reader immediately. When both ports write the same word on the same edge, the left port wins.

The array holds 2^ADDR_W words. The full-size build sets ADDR_W to 16 (65,536 bytes), or to 15 for a 32K-word part. The default is kept small.

Top module: `dpr_counter_ram`

## Requirements
- R1: The array stores 2^ADDR_W words of DATA_W bits. Every word written through port A can be read back through either port.
- R2: A port acts on an edge only when its enable `en0_n` is 0 and `en1` is 1 at that edge. Otherwise it writes nothing, and on the following cycles it does not drive its output.
- R3: While `ld_n` is 0, the port's address register takes `addr` on every rising edge. That address is the one accessed at that edge.
- R4: With `ld_n` at 1 and `step_n` at 0, the address register increases by one per edge and wraps from 2^ADDR_W-1 to 0. With both at 1, it holds.
- R5: `clr_n` at 0 sets the address register to 0 at the edge. This takes priority over load and count. `clr_n` at 1 has no effect.
- R6: A flow-through port (PIPE=0) drives the word at the address accessed at edge n during the cycle after edge n.
- R7: A pipelined port (PIPE=1) drives that word during the cycle after edge n+1. Whether it drives is decided by the select and write controls of edge n.
- R8: The drive flag is 0 whenever `oe_n` is 1, which takes effect without a clock. It is also 0 after reset, and for the cycle whose access was a write or a deselect. The data bus reads 0 whenever the flag is 0.
- R9: A selected port with `wr_n` at 0 stores `din` at the accessed address on that rising edge.
- R10: When one port writes the address the other port reads at the same edge, the reader returns the new byte. A write to a different address leaves the reader's data unaffected.
- R11: When both ports write the same address at the same edge, the left port's byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of address and output state |
| a_en0_n | input | 1 | Port A enable, active low |
| a_en1 | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A write strobe (0 = write, 1 = read) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_ld_n | input | 1 | Port A address load strobe, active low |
| a_step_n | input | 1 | Port A count enable, active low |
| a_clr_n | input | 1 | Port A address clear, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data (0 when not driven) |
| a_drv | output | 1 | Port A output drive flag |
| b_en0_n | input | 1 | Port B enable, active low |
| b_en1 | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B write strobe (0 = write, 1 = read) |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_ld_n | input | 1 | Port B address load strobe, active low |
| b_step_n | input | 1 | Port B count enable, active low |
| b_clr_n | input | 1 | Port B address clear, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data (0 when not driven) |
| b_drv | output | 1 | Port B output drive flag |

## Verification
The forwarding property assumes that port A is flow-through, that both ports load their addresses through the strobe, and that neither counter is being cleared. The stimulus forces equal addresses explicitly whenever a cross-port hit is intended. The mode-specific properties are generated only for the default pairing of a flow-through left port and a pipelined right port, which is the configuration the stimulus drives. Inputs change only a fixed delay after the rising edge, so every strobe is stable when it is sampled. The array is filled completely before any read, so no property or check sees an unwritten word.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;
endpackage

// File: rtl/dpr_core.sv
`timescale 1ns/1ps
module dpr_core #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wa_en,
    input  logic [ADDR_W-1:0] wa_addr,
    input  logic [DATA_W-1:0] wa_data,
    input  logic              wb_en,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] ra_addr,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              b_blocked;

    // the left port owns a word both ports write on the same edge
    assign b_blocked = wa_en && (wa_addr == wb_addr);

    always_ff @(posedge clk) begin
        if (wa_en) begin
            mem[wa_addr] <= wa_data;
        end
        if (wb_en && !b_blocked) begin
            mem[wb_addr] <= wb_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
module dpr_port
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter bit PIPE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              ld_n,
    input  logic              step_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] dout,
    output logic              drv
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd1;
        logic              rd2;
        logic [DATA_W-1:0] pdata;
    } port_st_t;

    port_st_t          st_d, st_q;
    port_op_e          op;
    logic [DATA_W-1:0] out_word;

    always_comb begin
        st_d = st_q;
        op   = OP_IDLE;
        if (!en0_n && en1) begin
            op = wr_n ? OP_READ : OP_WRITE;
        end
        // clear beats load, load beats count
        if (!clr_n) begin
            st_d.addr = '0;
        end else if (!ld_n) begin
            st_d.addr = addr_in;
        end else if (!step_n) begin
            st_d.addr = st_q.addr + 1'b1;
        end
        st_d.rd1   = (op == OP_READ);
        st_d.rd2   = st_q.rd1;
        st_d.pdata = mem_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_addr = st_d.addr;
    assign wr_en    = (op == OP_WRITE);
    assign rd_addr  = st_q.addr;

    generate
        if (PIPE) begin : g_pipe
            assign drv      = st_q.rd2 && !oe_n;
            assign out_word = st_q.pdata;
        end else begin : g_flow
            assign drv      = st_q.rd1 && !oe_n;
            assign out_word = mem_q;
        end
    endgenerate

    assign dout = drv ? out_word : '0;
endmodule

// File: rtl/dpr_counter_ram.sv
`timescale 1ns/1ps
module dpr_counter_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter bit PIPE_A = 1'b0,
    parameter bit PIPE_B = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en0_n,
    input  logic              a_en1,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic              a_ld_n,
    input  logic              a_step_n,
    input  logic              a_clr_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_drv,
    input  logic              b_en0_n,
    input  logic              b_en1,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic              b_ld_n,
    input  logic              b_step_n,
    input  logic              b_clr_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_drv
);
    logic [ADDR_W-1:0] a_acc, b_acc, a_rd, b_rd;
    logic              a_wen, b_wen;
    logic [DATA_W-1:0] a_mq, b_mq;

    dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE(PIPE_A)) u_port_a (
        .clk(clk), .rst_n(rst_n), .en0_n(a_en0_n), .en1(a_en1), .wr_n(a_wr_n),
        .oe_n(a_oe_n), .ld_n(a_ld_n), .step_n(a_step_n), .clr_n(a_clr_n),
        .addr_in(a_addr), .mem_q(a_mq), .acc_addr(a_acc), .wr_en(a_wen),
        .rd_addr(a_rd), .dout(a_dout), .drv(a_drv)
    );

    dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE(PIPE_B)) u_port_b (
        .clk(clk), .rst_n(rst_n), .en0_n(b_en0_n), .en1(b_en1), .wr_n(b_wr_n),
        .oe_n(b_oe_n), .ld_n(b_ld_n), .step_n(b_step_n), .clr_n(b_clr_n),
        .addr_in(b_addr), .mem_q(b_mq), .acc_addr(b_acc), .wr_en(b_wen),
        .rd_addr(b_rd), .dout(b_dout), .drv(b_drv)
    );

    dpr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk(clk),
        .wa_en(a_wen), .wa_addr(a_acc), .wa_data(a_din),
        .wb_en(b_wen), .wb_addr(b_acc), .wb_data(b_din),
        .ra_addr(a_rd), .rb_addr(b_rd), .ra_data(a_mq), .rb_data(b_mq)
    );
endmodule

// File: rtl/dpr_checks.sv
`timescale 1ns/1ps
module dpr_checks #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter bit PIPE_A = 1'b0,
    parameter bit PIPE_B = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en0_n,
    input logic              a_en1,
    input logic              a_wr_n,
    input logic              a_oe_n,
    input logic              a_ld_n,
    input logic              a_clr_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_drv,
    input logic              b_en0_n,
    input logic              b_en1,
    input logic              b_wr_n,
    input logic              b_oe_n,
    input logic              b_ld_n,
    input logic              b_clr_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_din,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_drv
);
    a_r8_oe_off_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> !a_drv);
    a_r8_oe_off_b: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |-> !b_drv);
    a_r8_quiet_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_drv |-> (a_dout == '0));
    a_r8_quiet_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_drv |-> (b_dout == '0));

    generate
        if (!PIPE_A) begin : g_flow_a
            a_r2_desel_flow: assert property (@(posedge clk) disable iff (!rst_n)
                (a_en0_n || !a_en1) |=> !a_drv);
            a_r8_write_quiet_flow: assert property (@(posedge clk) disable iff (!rst_n)
                (!a_en0_n && a_en1 && !a_wr_n) |=> !a_drv);
            a_r10_forward_flow: assert property (@(posedge clk) disable iff (!rst_n)
                (!b_en0_n && b_en1 && !b_wr_n && !b_ld_n && b_clr_n &&
                 !a_en0_n && a_en1 && a_wr_n && !a_ld_n && a_clr_n &&
                 (a_addr == b_addr))
                |=> (a_oe_n || (a_dout == $past(b_din))));
        end
        if (PIPE_B) begin : g_pipe_b
            a_r7_desel_pipe: assert property (@(posedge clk) disable iff (!rst_n)
                (b_en0_n || !b_en1) |=> ##1 !b_drv);
            a_r7_write_quiet_pipe: assert property (@(posedge clk) disable iff (!rst_n)
                (!b_en0_n && b_en1 && !b_wr_n) |=> ##1 !b_drv);
        end
    endgenerate
endmodule

bind dpr_counter_ram dpr_checks #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIPE_A(PIPE_A), .PIPE_B(PIPE_B)
) u_checks (
    .clk(clk), .rst_n(rst_n),
    .a_en0_n(a_en0_n), .a_en1(a_en1), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
    .a_ld_n(a_ld_n), .a_clr_n(a_clr_n), .a_addr(a_addr),
    .a_dout(a_dout), .a_drv(a_drv),
    .b_en0_n(b_en0_n), .b_en1(b_en1), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
    .b_ld_n(b_ld_n), .b_clr_n(b_clr_n), .b_addr(b_addr), .b_din(b_din),
    .b_dout(b_dout), .b_drv(b_drv)
);

// File: tb/tb_dpr_counter_ram.sv
`timescale 1ns/1ps
module tb_dpr_counter_ram;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       a_en0_n, a_en1, a_wr_n, a_oe_n, a_ld_n, a_step_n, a_clr_n;
    logic [7:0] a_addr, a_din, a_dout;
    logic       a_drv;
    logic       b_en0_n, b_en1, b_wr_n, b_oe_n, b_ld_n, b_step_n, b_clr_n;
    logic [7:0] b_addr, b_din, b_dout;
    logic       b_drv;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    dpr_counter_ram #(.ADDR_W(8), .DATA_W(8), .PIPE_A(1'b0), .PIPE_B(1'b1)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_en0_n(a_en0_n), .a_en1(a_en1), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n),
        .a_ld_n(a_ld_n), .a_step_n(a_step_n), .a_clr_n(a_clr_n),
        .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout), .a_drv(a_drv),
        .b_en0_n(b_en0_n), .b_en1(b_en1), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n),
        .b_ld_n(b_ld_n), .b_step_n(b_step_n), .b_clr_n(b_clr_n),
        .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout), .b_drv(b_drv)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(((i & 255) * 37 + 11) & 255);
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_en0_n = 1'b0; a_en1 = 1'b1; a_wr_n = 1'b1; a_oe_n = 1'b0;
        a_ld_n = 1'b1; a_step_n = 1'b1; a_clr_n = 1'b1; a_addr = '0; a_din = '0;
        b_en0_n = 1'b0; b_en1 = 1'b1; b_wr_n = 1'b1; b_oe_n = 1'b0;
        b_ld_n = 1'b1; b_step_n = 1'b1; b_clr_n = 1'b1; b_addr = '0; b_din = '0;
        repeat (3) tick();
        chk("R8 reset a_drv", {7'b0, a_drv}, 8'h00);
        chk("R8 reset b_drv", {7'b0, b_drv}, 8'h00);
        rst_n = 1'b1;

        // R9 R3: fill every word from port A, B deselected
        b_en1 = 1'b0;
        for (int i = 0; i < 256; i++) begin
            a_ld_n = 1'b0; a_addr = 8'(i); a_wr_n = 1'b0; a_din = pat(i);
            tick();
            if (i == 5) chk("R8 write cycle a_drv", {7'b0, a_drv}, 8'h00);
        end
        a_wr_n = 1'b1;
        b_en1  = 1'b1;

        // R1 R4 R5 R6 R7: B counts from cleared zero, A loads descending
        for (int k = 0; k <= 257; k++) begin
            b_clr_n = (k != 0); b_step_n = 1'b0; b_ld_n = 1'b1;
            a_ld_n = 1'b0; a_addr = 8'(255 - k);
            tick();
            chk("R6 R1 flow-through read", a_dout, pat(255 - k));
            if (k >= 1) begin
                if (k == 257) chk("R4 wrap to zero", b_dout, pat(0));
                else if (k == 1) chk("R5 clear priority", b_dout, pat(0));
                else chk("R7 R1 pipelined count read", b_dout, pat(k - 1));
                chk("R7 pipelined drive", {7'b0, b_drv}, 8'h01);
            end
        end

        // R4 hold with both strobes high
        b_step_n = 1'b1; b_ld_n = 1'b0; b_addr = 8'd10;
        tick();
        b_ld_n = 1'b1;
        tick();
        tick();
        chk("R4 hold", b_dout, pat(10));
        tick();
        chk("R4 hold again", b_dout, pat(10));

        // R8 output enable, unclocked
        a_ld_n = 1'b0; a_addr = 8'd3; a_oe_n = 1'b1;
        tick();
        chk("R8 oe off drv", {7'b0, a_drv}, 8'h00);
        chk("R8 oe off data", a_dout, 8'h00);
        a_oe_n = 1'b0;
        #1;
        chk("R8 oe on drv", {7'b0, a_drv}, 8'h01);
        chk("R8 oe on data", a_dout, pat(3));

        // R2 deselect on A
        a_en1 = 1'b0;
        tick();
        chk("R2 a deselect drv", {7'b0, a_drv}, 8'h00);
        a_en1 = 1'b1;
        a_en0_n = 1'b1; a_wr_n = 1'b0; a_addr = 8'd30; a_din = 8'h00;
        tick();
        a_en0_n = 1'b0; a_wr_n = 1'b1;
        tick();
        chk("R2 deselected write ignored a", a_dout, pat(30));

        // R2 R7 deselect on B, then reselect
        b_en0_n = 1'b1; b_wr_n = 1'b0; b_ld_n = 1'b0; b_addr = 8'd20; b_din = 8'hFF;
        tick();
        tick();
        chk("R2 b deselect drv", {7'b0, b_drv}, 8'h00);
        b_en0_n = 1'b0; b_wr_n = 1'b1;
        tick();
        chk("R7 drive from previous controls", {7'b0, b_drv}, 8'h00);
        tick();
        chk("R7 drive after reselect", {7'b0, b_drv}, 8'h01);
        chk("R2 deselected write ignored b", b_dout, pat(20));

        // R8 R9 pipelined write cycle does not drive
        b_wr_n = 1'b0; b_addr = 8'd21; b_din = 8'h9C;
        tick();
        b_wr_n = 1'b1;
        tick();
        chk("R8 b write cycle drv", {7'b0, b_drv}, 8'h00);
        tick();
        chk("R9 b write readback", b_dout, 8'h9C);

        // R10 forwarding into flow-through A
        b_wr_n = 1'b0; b_addr = 8'd40; b_din = 8'h5A; a_addr = 8'd40;
        tick();
        chk("R10 forward to A", a_dout, 8'h5A);
        b_addr = 8'd42; b_din = 8'h11; a_addr = 8'd41;
        tick();
        chk("R10 no match A", a_dout, pat(41));
        b_wr_n = 1'b1;

        // R10 forwarding into pipelined B
        a_wr_n = 1'b0; a_addr = 8'd50; a_din = 8'hC3; b_addr = 8'd50;
        tick();
        a_wr_n = 1'b1; a_addr = 8'd0;
        tick();
        chk("R10 forward to B", b_dout, 8'hC3);

        // R11 same-address collision
        a_wr_n = 1'b0; b_wr_n = 1'b0; a_addr = 8'd60; b_addr = 8'd60;
        a_din = 8'hAA; b_din = 8'h55;
        tick();
        a_wr_n = 1'b1; b_wr_n = 1'b1;
        tick();
        chk("R11 left wins via A", a_dout, 8'hAA);
        tick();
        chk("R11 left wins via B", b_dout, 8'hAA);

        // R9 earlier B writes persist
        a_addr = 8'd42;
        tick();
        chk("R9 b write stored", a_dout, 8'h11);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule